// File: doc/BRIEF.md
# Single and Double Tap Detector

This block watches a stream of signed acceleration samples on three axes and recognises short impacts ("taps"). On each axis a tap is a brief excursion of the sample magnitude above that axis's own threshold that returns below the threshold quickly enough. After a first tap, a blanking interval hides the rebounds of the impact. An acceptance window follows, and a second tap inside it turns the event into a double tap.

Results are collected in sticky status flags: an event-active flag, one flag per axis, and a double-tap marker. They stay set until a one-cycle clear pulse arrives, which is normally sent when the host reads the status. An interrupt output follows the event-active flag behind an enable. All timing values count sample strobes, not clock cycles.

Top module: `tap_detector`

## Requirements
- R1: After reset the event-active flag, all three axis flags, the double-tap marker and the interrupt are 0.
- R2: Samples are 8-bit two's complement. An axis exceeds its threshold only when the magnitude of its sample is strictly greater than its 7-bit unsigned threshold. A magnitude equal to the threshold does not count, and -128 counts as magnitude 128.
- R3: A tap is recognised on the strobed sample at which the magnitude drops back to the threshold or below. It is accepted only if the run of consecutive strobed samples above the threshold is no longer than the time-limit value. A limit of 0 accepts nothing.
- R4: Let the first tap end on sample s, with latency L. Taps ending on samples s+1 to s+L are ignored.
- R5: With window W>0, a tap ending on sample s+L+1 to s+L+W, on an axis with double detection enabled, reports a double tap. The axis flags show the axes of that second tap and the double-tap marker is 1.
- R6: If the window closes with no second tap, a single tap is reported for the axes of the first tap that have single detection enabled, with the marker 0. If none of those axes has single detection enabled, nothing is reported.
- R7: If the window value is 0, or no axis of a tap has double detection enabled, a single tap is reported at once for that tap's axes that have single detection enabled.
- R8: A tap on an axis with neither single nor double detection enabled changes no flag.
- R9: The flags hold until a clear pulse. Later events OR their axes into the axis flags, and the double-tap marker keeps the value of the event that first set the event-active flag. A clear on its own zeroes every flag.
- R10: If a clear and a new report fall in the same cycle, the report wins and the flags show only the new event.
- R11: The interrupt is high exactly when the event-active flag is set and the interrupt enable is high.
- R12: A second tap that ends on the last window sample (s+L+W) is reported as a double tap, even though the window closes on that same sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| smp_valid_i | input | 1 | Sample strobe, one cycle per sample set |
| acc_x_i | input | 8 | X sample, two's complement |
| acc_y_i | input | 8 | Y sample, two's complement |
| acc_z_i | input | 8 | Z sample, two's complement |
| thr_x_i | input | 7 | X threshold, unsigned |
| thr_y_i | input | 7 | Y threshold, unsigned |
| thr_z_i | input | 7 | Z threshold, unsigned |
| tmlt_i | input | 8 | Maximum run of above-threshold samples in a tap |
| lat_i | input | 8 | Blanking interval after a first tap, in samples |
| win_i | input | 8 | Second-tap window in samples, 0 disables double taps |
| sgl_en_i | input | 3 | Single-tap enable per axis (bit0 X, bit1 Y, bit2 Z) |
| dbl_en_i | input | 3 | Double-tap enable per axis (bit0 X, bit1 Y, bit2 Z) |
| irq_en_i | input | 1 | Interrupt enable |
| clr_i | input | 1 | One-cycle clear of the status flags |
| ea_o | output | 1 | Event-active flag |
| axes_o | output | 3 | Axis event flags (bit0 X, bit1 Y, bit2 Z) |
| dbl_o | output | 1 | Double-tap marker |
| irq_o | output | 1 | Interrupt |

## Verification
Two pairs of functions can coincide in one cycle. The first pair is the arrival of a second tap and the closing of the window. It is provoked by sweeping the gap between two taps across every latency and window value from 0 to 3, so that the gap equal to latency plus window lands on the closing sample, where a double tap must win. The second pair is a host clear and a new report. It is provoked by raising the clear in exactly the cycle the report latches, on top of an older event on another axis; only the new axis may remain flagged.

// File: rtl/tap_pkg.sv
package tap_pkg;
  localparam int unsigned NUM_AXES = 3;
  typedef enum logic [1:0] {ST_IDLE, ST_LAT, ST_WIN} seq_state_e;
endpackage

// File: rtl/tap_axis_qual.sv
module tap_axis_qual #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] sample_i,
  input  logic [DATA_W-2:0] thr_i,
  input  logic [CNT_W-1:0]  tmlt_i,
  output logic              pulse_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [DATA_W-1:0] mag;
  logic              above;
  logic              above_q, pulse_q;
  logic [CNT_W-1:0]  cnt_q;

  always_comb mag = sample_i[DATA_W-1] ? (~sample_i + 1'b1) : sample_i;
  assign above = mag > {1'b0, thr_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      above_q <= 1'b0;
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= 1'b0;
      if (valid_i) begin
        if (above) begin
          above_q <= 1'b1;
          if (!above_q)             cnt_q <= CNT_ONE;
          else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
        end else begin
          above_q <= 1'b0;
          cnt_q   <= '0;
          pulse_q <= above_q && (cnt_q <= tmlt_i);
        end
      end
    end
  end

  assign pulse_o = pulse_q;

  AST_PULSE_ON_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |-> $past(valid_i)); // R3
  AST_ZERO_LIMIT_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmlt_i == '0 && $stable(tmlt_i)) |-> !pulse_o); // R3
endmodule

// File: rtl/tap_sequencer.sv
module tap_sequencer
  import tap_pkg::*;
#(
  parameter int unsigned NA    = NUM_AXES,
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [NA-1:0]    pulse_i,
  input  logic [CNT_W-1:0] lat_i,
  input  logic [CNT_W-1:0] win_i,
  input  logic [NA-1:0]    sgl_en_i,
  input  logic [NA-1:0]    dbl_en_i,
  output logic             rep_o,
  output logic [NA-1:0]    rep_axes_o,
  output logic             rep_dbl_o
);
  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] tmr_q, tmr_d;
  logic [NA-1:0]    pend_q, pend_d;
  logic             rep_q, rep_d, rep_dbl_q, rep_dbl_d;
  logic [NA-1:0]    rep_axes_q, rep_axes_d;
  logic [NA-1:0]    sgl_hit, dbl_hit;

  assign sgl_hit = pulse_i & sgl_en_i;
  assign dbl_hit = pulse_i & dbl_en_i;

  always_comb begin
    state_d    = state_q;
    tmr_d      = tmr_q;
    pend_d     = pend_q;
    rep_d      = 1'b0;
    rep_axes_d = '0;
    rep_dbl_d  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (|dbl_hit && win_i != '0) begin
          state_d = ST_LAT;
          tmr_d   = '0;
          pend_d  = sgl_hit;
        end else if (|sgl_hit) begin
          rep_d      = 1'b1;
          rep_axes_d = sgl_hit;
        end
      end
      ST_LAT: begin
        // pulses are blanked here
        if (tmr_q >= lat_i) begin
          state_d = ST_WIN;
          tmr_d   = '0;
        end else if (valid_i) begin
          tmr_d = tmr_q + 1'b1;
        end
      end
      ST_WIN: begin
        // a second tap beats window closure in the same cycle
        if (|dbl_hit) begin
          rep_d      = 1'b1;
          rep_axes_d = dbl_hit;
          rep_dbl_d  = 1'b1;
          state_d    = ST_IDLE;
          pend_d     = '0;
        end else if (tmr_q >= win_i) begin
          rep_d      = |pend_q;
          rep_axes_d = pend_q;
          state_d    = ST_IDLE;
          pend_d     = '0;
        end else if (valid_i) begin
          tmr_d = tmr_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      tmr_q      <= '0;
      pend_q     <= '0;
      rep_q      <= 1'b0;
      rep_axes_q <= '0;
      rep_dbl_q  <= 1'b0;
    end else begin
      state_q    <= state_d;
      tmr_q      <= tmr_d;
      pend_q     <= pend_d;
      rep_q      <= rep_d;
      rep_axes_q <= rep_axes_d;
      rep_dbl_q  <= rep_dbl_d;
    end
  end

  assign rep_o      = rep_q;
  assign rep_axes_o = rep_axes_q;
  assign rep_dbl_o  = rep_dbl_q;

  AST_LAT_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LAT) |=> !rep_q); // R4
  AST_DBL_FROM_WIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rep_q && rep_dbl_q) |-> ($past(state_q) == ST_WIN)); // R5
  AST_ZERO_WIN_NO_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && win_i == '0) |=> state_q != ST_LAT); // R7
endmodule

// File: rtl/tap_status.sv
module tap_status
  import tap_pkg::*;
#(
  parameter int unsigned NA = NUM_AXES
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rep_i,
  input  logic [NA-1:0] rep_axes_i,
  input  logic          rep_dbl_i,
  input  logic          clr_i,
  output logic          ea_o,
  output logic [NA-1:0] axes_o,
  output logic          dbl_o
);
  logic          ea_q, dbl_q, base_ea, base_dbl;
  logic [NA-1:0] axes_q, base_axes;

  assign base_ea   = clr_i ? 1'b0 : ea_q;
  assign base_dbl  = clr_i ? 1'b0 : dbl_q;
  assign base_axes = clr_i ? '0 : axes_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ea_q   <= 1'b0;
      axes_q <= '0;
      dbl_q  <= 1'b0;
    end else begin
      ea_q   <= base_ea | rep_i;
      axes_q <= base_axes | (rep_i ? rep_axes_i : '0);
      dbl_q  <= base_ea ? base_dbl : (rep_i & rep_dbl_i);
    end
  end

  assign ea_o   = ea_q;
  assign axes_o = axes_q;
  assign dbl_o  = dbl_q;

  AST_EA_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ea_q && !clr_i) |=> ea_q); // R9
  AST_CLEAR_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !rep_i) |=> (!ea_q && axes_q == '0 && !dbl_q)); // R9
  AST_REPORT_OVER_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && rep_i) |=> (ea_q && axes_q == $past(rep_axes_i))); // R10
endmodule

// File: rtl/tap_detector.sv
module tap_detector
  import tap_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                smp_valid_i,
  input  logic [DATA_W-1:0]   acc_x_i,
  input  logic [DATA_W-1:0]   acc_y_i,
  input  logic [DATA_W-1:0]   acc_z_i,
  input  logic [DATA_W-2:0]   thr_x_i,
  input  logic [DATA_W-2:0]   thr_y_i,
  input  logic [DATA_W-2:0]   thr_z_i,
  input  logic [CNT_W-1:0]    tmlt_i,
  input  logic [CNT_W-1:0]    lat_i,
  input  logic [CNT_W-1:0]    win_i,
  input  logic [NUM_AXES-1:0] sgl_en_i,
  input  logic [NUM_AXES-1:0] dbl_en_i,
  input  logic                irq_en_i,
  input  logic                clr_i,
  output logic                ea_o,
  output logic [NUM_AXES-1:0] axes_o,
  output logic                dbl_o,
  output logic                irq_o
);
  localparam int unsigned NA    = NUM_AXES;
  localparam int unsigned THR_W = DATA_W - 1;

  logic [DATA_W-1:0] smp [NA];
  logic [THR_W-1:0]  thr [NA];
  logic [NA-1:0]     pulse;
  logic              rep, rep_dbl;
  logic [NA-1:0]     rep_axes;

  assign smp[0] = acc_x_i;
  assign smp[1] = acc_y_i;
  assign smp[2] = acc_z_i;
  assign thr[0] = thr_x_i;
  assign thr[1] = thr_y_i;
  assign thr[2] = thr_z_i;

  for (genvar a = 0; a < NA; a++) begin : g_axis
    tap_axis_qual #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_qual (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .valid_i (smp_valid_i),
      .sample_i(smp[a]),
      .thr_i   (thr[a]),
      .tmlt_i  (tmlt_i),
      .pulse_o (pulse[a])
    );
  end

  tap_sequencer #(.NA(NA), .CNT_W(CNT_W)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (smp_valid_i),
    .pulse_i   (pulse),
    .lat_i     (lat_i),
    .win_i     (win_i),
    .sgl_en_i  (sgl_en_i),
    .dbl_en_i  (dbl_en_i),
    .rep_o     (rep),
    .rep_axes_o(rep_axes),
    .rep_dbl_o (rep_dbl)
  );

  tap_status #(.NA(NA)) u_stat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rep_i     (rep),
    .rep_axes_i(rep_axes),
    .rep_dbl_i (rep_dbl),
    .clr_i     (clr_i),
    .ea_o      (ea_o),
    .axes_o    (axes_o),
    .dbl_o     (dbl_o)
  );

  assign irq_o = ea_o & irq_en_i;

  AST_AXES_NEED_EA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|axes_o) |-> ea_o); // R9
  AST_UNUSED_AXIS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rep && !$past(clr_i, 1)) |-> ((rep_axes & ~(sgl_en_i | dbl_en_i)) == '0 || $changed(sgl_en_i) || $changed(dbl_en_i))); // R8
endmodule

// File: tb/tap_detector_tb.sv
module tap_detector_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       vld = 1'b0;
  logic [7:0] ax = '0, ay = '0, az = '0;
  logic [6:0] tx = 7'd10, ty = 7'd10, tz = 7'd10;
  logic [7:0] tmlt = 8'd4, lat = '0, win = '0;
  logic [2:0] sgl_en = 3'b111, dbl_en = 3'b000;
  logic       irq_en = 1'b1, clr = 1'b0;
  logic       ea, dbl, irq;
  logic [2:0] axes;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tap_detector u_dut (
    .clk_i(clk), .rst_ni(rst_n), .smp_valid_i(vld),
    .acc_x_i(ax), .acc_y_i(ay), .acc_z_i(az),
    .thr_x_i(tx), .thr_y_i(ty), .thr_z_i(tz),
    .tmlt_i(tmlt), .lat_i(lat), .win_i(win),
    .sgl_en_i(sgl_en), .dbl_en_i(dbl_en), .irq_en_i(irq_en), .clr_i(clr),
    .ea_o(ea), .axes_o(axes), .dbl_o(dbl), .irq_o(irq)
  );

  task automatic send3(input logic [7:0] x, input logic [7:0] y, input logic [7:0] z);
    @(negedge clk); ax = x; ay = y; az = z; vld = 1'b1;
    @(negedge clk); vld = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic quiet(input int n);
    for (int i = 0; i < n; i++) send3(8'd0, 8'd0, 8'd0);
  endtask

  task automatic tap(input int axis, input int width, input logic [7:0] amp);
    for (int i = 0; i < width; i++)
      send3(axis == 0 ? amp : 8'd0, axis == 1 ? amp : 8'd0, axis == 2 ? amp : 8'd0);
    send3(8'd0, 8'd0, 8'd0);
  endtask

  task automatic clear_flags();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic chk(input string req, input logic [4:0] exp_v);
    @(negedge clk);
    checks++;
    if ({ea, axes, dbl} !== exp_v) begin
      errors++;
      $display("FAIL %s: {ea,axes,dbl} actual=%b expected=%b", req, {ea, axes, dbl}, exp_v);
    end
  endtask

  task automatic chk_irq(input string req, input logic exp_v);
    @(negedge clk);
    checks++;
    if (irq !== exp_v) begin
      errors++;
      $display("FAIL %s: irq actual=%b expected=%b", req, irq, exp_v);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", 5'b0_000_0);
    chk_irq("R1", 1'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2: magnitude strictly above threshold, single path
    begin
      int amps [9] = '{19, 20, 21, -20, -21, 0, 5, -128, 127};
      for (int i = 0; i < 9; i++) begin
        int mag;
        tz = (i >= 7) ? 7'd127 : 7'd20;
        mag = amps[i] < 0 ? -amps[i] : amps[i];
        clear_flags();
        tap(2, 1, amps[i][7:0]);
        quiet(2);
        chk("R2", (mag > int'(tz)) ? 5'b1_100_0 : 5'b0_000_0);
      end
      tz = 7'd10;
    end

    // R3: time limit on the above-threshold run
    tmlt = 8'd3;
    for (int w = 1; w <= 5; w++) begin
      clear_flags();
      tap(0, w, 8'd50);
      quiet(2);
      chk("R3", (w <= 3) ? 5'b1_001_0 : 5'b0_000_0);
    end
    tmlt = 8'd0;
    clear_flags();
    tap(0, 1, 8'd50);
    quiet(2);
    chk("R3", 5'b0_000_0);
    tmlt = 8'd4;

    // R8: axis with no enable
    sgl_en = 3'b011; dbl_en = 3'b011; win = 8'd2;
    clear_flags();
    tap(2, 1, 8'd50);
    quiet(8);
    chk("R8", 5'b0_000_0);
    // R6: window closes, first-tap axis has no single enable
    sgl_en = 3'b010;
    clear_flags();
    tap(0, 1, 8'd50);
    quiet(8);
    chk("R6", 5'b0_000_0);

    // R4 R5 R6 R7 R12: sweep latency, window and gap between taps
    sgl_en = 3'b111; dbl_en = 3'b011;
    for (int l = 0; l <= 3; l++) begin
      for (int w = 0; w <= 3; w++) begin
        for (int k = 2; k <= 9; k++) begin
          logic [4:0] exp_v;
          string req;
          lat = l[7:0]; win = w[7:0];
          quiet(2);
          clear_flags();
          tap(0, 1, 8'd50);
          quiet(k - 2);
          tap(1, 1, 8'd50);
          quiet(14);
          if (w == 0)              begin exp_v = 5'b1_011_0; req = "R7"; end
          else if (k <= l)         begin exp_v = 5'b1_001_0; req = "R4"; end
          else if (k == l + w)     begin exp_v = 5'b1_010_1; req = "R12"; end
          else if (k < l + w)      begin exp_v = 5'b1_010_1; req = "R5"; end
          else                     begin exp_v = 5'b1_011_0; req = "R6"; end
          chk(req, exp_v);
        end
      end
    end

    // R9: sticky flags, OR of axes, marker of first event kept
    lat = 8'd0; win = 8'd2; sgl_en = 3'b111; dbl_en = 3'b111;
    clear_flags();
    tap(0, 1, 8'd50);
    tap(1, 1, 8'd50);
    quiet(6);
    chk("R9", 5'b1_010_1);
    win = 8'd0;
    tap(2, 1, 8'd50);
    quiet(6);
    chk("R9", 5'b1_110_1);

    // R11: interrupt gating
    irq_en = 1'b0;
    chk_irq("R11", 1'b0);
    irq_en = 1'b1;
    chk_irq("R11", 1'b1);

    clear_flags();
    chk("R9", 5'b0_000_0);
    chk_irq("R11", 1'b0);

    // R10: clear lands in the cycle the new report latches
    tap(0, 1, 8'd50);
    quiet(2);
    chk("R10", 5'b1_001_0);
    send3(8'd0, 8'd50, 8'd0);
    @(negedge clk); ax = '0; ay = '0; az = '0; vld = 1'b1;
    @(negedge clk); vld = 1'b0;
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    quiet(2);
    chk("R10", 5'b1_010_0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule